// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual-to-physical translation in hardware when the translation buffer misses. It takes one 32-bit virtual address from the buffer's miss path and walks a two-level table held in memory. The top ten address bits index a first-level table whose base comes from a base-register input. That entry, if valid, gives the 4 KB-aligned base of a second-level table, which the next ten bits index. The valid second-level entry supplies the physical frame, a dirty flag and three access-rights bits. The buffer inserts these, and the original access completes with the physical address.

An invalid entry at either level ends the walk with a page-fault abort rather than a translation. The abort reports the level that failed and the faulting virtual address, and no translation is returned. Only one walk runs at a time. The memory side is a single-outstanding read port. A one-cycle request strobe carries a byte address, and a later one-cycle valid strobe returns the 32-bit entry.

Top module: `tbl_walker`

## Requirements
- R1: After reset `reqReady` is 1 and `memReqValid` and `respValid` are 0, and no memory read or response appears before the first accepted request.
- R2: A request is taken only when `reqValid` and `reqReady` are both high. `reqReady` is 0 from the cycle after acceptance until the response handshake completes, and `reqValid` held during a walk starts no second walk.
- R3: The cycle after acceptance, `memReqValid` is high for exactly one cycle with `memReqAddr` = base + 4 × vaddr[31:22], where base is the `tableBase` value at acceptance.
- R4: A first-level entry with bit 0 = 0 ends the walk with `respValid`=1, `respFault`=1, `respFaultLevel`=0 and `respVaddr` equal to the request. No second read is issued.
- R5: For a first-level entry with bit 0 = 1, the cycle after its data returns carries a one-cycle read at {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R6: A second-level entry with bit 0 = 0 ends the walk with `respFault`=1 and `respFaultLevel`=1.
- R7: A second-level entry with bit 0 = 1 gives `respFault`=0 and the following fields from that entry: `respPpn` = entry[31:12], `respDirty` = entry[1], `respRights` = entry[4:2]. It also gives `respPaddr` = {entry[31:12], vaddr[11:0]}.
- R8: While `respValid`=1 and `respReady`=0, every response output holds. The cycle after `respValid` and `respReady` are both high, `respValid` is 0 and `reqReady` is 1.
- R9: At most one memory read is outstanding. A `memRspValid` pulse that arrives while no read is pending has no effect.
- R10: A change of `tableBase` after acceptance does not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 32 | Virtual address to translate |
| tableBase | input | 32 | Byte address of the first-level table |
| memReqValid | output | 1 | One-cycle read strobe |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Table entry returned by memory |
| respValid | output | 1 | Walk result present |
| respReady | input | 1 | Result taken by the buffer |
| respFault | output | 1 | 1 = page-fault abort, 0 = translation |
| respFaultLevel | output | 1 | On a fault: 0 = first level invalid, 1 = second level invalid |
| respVaddr | output | 32 | Virtual address of the walk |
| respPpn | output | 20 | Physical page number |
| respDirty | output | 1 | Dirty flag of the page |
| respRights | output | 3 | Access-rights bits of the page |
| respPaddr | output | 32 | Physical address of the original access |

## Verification
Suppose the state machine skips or repeats a state. The first sign is on the memory port in the cycle it happens: a strobe of two cycles, a missing second read, or a read issued while one is pending. A wrong fault decision reaches `respFault` and `respFaultLevel` one cycle after the entry data returns. A corrupted captured address or frame shows only at the response handshake, so every walk's response is compared there against values computed from the bench's own memory image. A lost return path shows as a state that never settles, which the bench catches as a hang.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_READ_L1,
    WS_WAIT_L1,
    WS_READ_L2,
    WS_WAIT_L2,
    WS_DONE,
    WS_FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;   // capture request and base
    logic issueL2;   // address mux selects second-level entry
    logic grabL1;    // first-level entry on the data bus
    logic grabL2;    // second-level entry on the data bus
  } walkStrobe_t;

  // entry field positions (decoded by the translation buffer)
  localparam int unsigned VALID_BIT  = 0;
  localparam int unsigned DIRTY_BIT  = 1;
  localparam int unsigned RIGHTS_LSB = 2;
  localparam int unsigned RIGHTS_W   = 3;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        respReady,
  input  logic        memRspValid,
  input  logic        entryValid,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        respValid,
  output logic        respIsFault
);

  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      WS_IDLE:    if (reqValid) stateNext = WS_READ_L1;
      WS_READ_L1: stateNext = WS_WAIT_L1;
      WS_WAIT_L1: if (memRspValid) stateNext = entryValid ? WS_READ_L2 : WS_FAULT;
      WS_READ_L2: stateNext = WS_WAIT_L2;
      WS_WAIT_L2: if (memRspValid) stateNext = entryValid ? WS_DONE : WS_FAULT;
      WS_DONE,
      WS_FAULT:   if (respReady) stateNext = WS_IDLE;
      default:    stateNext = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WS_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.takeReq = (state == WS_IDLE) && reqValid;
    strobe.issueL2 = (state == WS_READ_L2);
    strobe.grabL1  = (state == WS_WAIT_L1) && memRspValid;
    strobe.grabL2  = (state == WS_WAIT_L2) && memRspValid;
  end

  assign reqReady    = (state == WS_IDLE);
  assign memReqValid = (state == WS_READ_L1) || (state == WS_READ_L2);
  assign respValid   = (state == WS_DONE) || (state == WS_FAULT);
  assign respIsFault = (state == WS_FAULT);

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  localparam int VA_W    = OFF_W + 2 * IDX_W,
  localparam int FRAME_W = PTE_W - OFF_W,
  localparam int PA_W    = FRAME_W + OFF_W
)(
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [ADDR_W-1:0]   tableBase,
  input  logic [PTE_W-1:0]    memRspData,
  output logic                entryValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [VA_W-1:0]     respVaddr,
  output logic [FRAME_W-1:0]  respPpn,
  output logic                respDirty,
  output logic [RIGHTS_W-1:0] respRights,
  output logic [PA_W-1:0]     respPaddr,
  output logic                respFaultLevel
);

  localparam int BYTE_SH = $clog2(PTE_W / 8);
  localparam int LEVELS  = 2;

  logic [VA_W-1:0]     vaddrQ;
  logic [ADDR_W-1:0]   baseQ;
  logic [FRAME_W-1:0]  nextTableQ;
  logic [FRAME_W-1:0]  ppnQ;
  logic                dirtyQ;
  logic [RIGHTS_W-1:0] rightsQ;
  logic                levelQ;

  // per-level index fields, most significant level first
  logic [IDX_W-1:0]  levelIdx  [LEVELS];
  logic [ADDR_W-1:0] levelOffs [LEVELS];

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    assign levelIdx[lv]  = vaddrQ[OFF_W + (LEVELS - 1 - lv) * IDX_W +: IDX_W];
    assign levelOffs[lv] = ADDR_W'({levelIdx[lv], {BYTE_SH{1'b0}}});
  end

  logic [ADDR_W-1:0] l1Addr, l2Addr;
  assign l1Addr = baseQ + levelOffs[0];
  assign l2Addr = ADDR_W'({nextTableQ, {OFF_W{1'b0}}}) + levelOffs[1];
  assign memReqAddr = strobe.issueL2 ? l2Addr : l1Addr;

  assign entryValid = memRspData[VALID_BIT];

  logic [OFF_W-1:RIGHTS_LSB+RIGHTS_W] unusedEntryBits;
  assign unusedEntryBits = memRspData[OFF_W-1:RIGHTS_LSB+RIGHTS_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      baseQ      <= '0;
      nextTableQ <= '0;
      ppnQ       <= '0;
      dirtyQ     <= 1'b0;
      rightsQ    <= '0;
      levelQ     <= 1'b0;
    end else begin
      if (strobe.takeReq) begin
        vaddrQ  <= reqVaddr;
        baseQ   <= tableBase;
        ppnQ    <= '0;
        dirtyQ  <= 1'b0;
        rightsQ <= '0;
        levelQ  <= 1'b0;
      end
      if (strobe.grabL1) begin
        nextTableQ <= memRspData[PTE_W-1:OFF_W];
      end
      if (strobe.grabL2) begin
        ppnQ    <= memRspData[PTE_W-1:OFF_W];
        dirtyQ  <= memRspData[DIRTY_BIT];
        rightsQ <= memRspData[RIGHTS_LSB +: RIGHTS_W];
        levelQ  <= 1'b1;
      end
    end
  end

  assign respVaddr      = vaddrQ;
  assign respPpn        = ppnQ;
  assign respDirty      = dirtyQ;
  assign respRights     = rightsQ;
  assign respPaddr      = {ppnQ, vaddrQ[OFF_W-1:0]};
  assign respFaultLevel = levelQ;

endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  localparam int VA_W    = OFF_W + 2 * IDX_W,
  localparam int FRAME_W = PTE_W - OFF_W,
  localparam int PA_W    = FRAME_W + OFF_W
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [ADDR_W-1:0]   tableBase,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [PTE_W-1:0]    memRspData,
  output logic                respValid,
  input  logic                respReady,
  output logic                respFault,
  output logic                respFaultLevel,
  output logic [VA_W-1:0]     respVaddr,
  output logic [FRAME_W-1:0]  respPpn,
  output logic                respDirty,
  output logic [RIGHTS_W-1:0] respRights,
  output logic [PA_W-1:0]     respPaddr
);

  walkStrobe_t strobe;
  logic        entryValid;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .respReady   (respReady),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .respValid   (respValid),
    .respIsFault (respFault)
  );

  walk_datapath #(
    .ADDR_W (ADDR_W),
    .PTE_W  (PTE_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqVaddr       (reqVaddr),
    .tableBase      (tableBase),
    .memRspData     (memRspData),
    .entryValid     (entryValid),
    .memReqAddr     (memReqAddr),
    .respVaddr      (respVaddr),
    .respPpn        (respPpn),
    .respDirty      (respDirty),
    .respRights     (respRights),
    .respPaddr      (respPaddr),
    .respFaultLevel (respFaultLevel)
  );

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [VA_W-1:0]   reqVaddr,
  input logic [ADDR_W-1:0] tableBase,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              respValid,
  input logic              respReady,
  input logic              respFault,
  input logic              respFaultLevel,
  input logic [VA_W-1:0]   respVaddr,
  input logic [PA_W-1:0]   respPaddr
);

  logic pending;
  logic seenAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      seenAccept <= 1'b0;
    end else begin
      if (memReqValid)      pending <= 1'b1;
      else if (memRspValid) pending <= 1'b0;
      if (reqValid && reqReady) seenAccept <= 1'b1;
    end
  end

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seenAccept |-> (!memReqValid && !respValid))
    else $error("quiet before first request");

  assert_busy_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || respValid) |-> !reqReady)
    else $error("ready while busy");

  assert_first_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memReqValid &&
      memReqAddr == $past(tableBase) + ADDR_W'({$past(reqVaddr[VA_W-1 -: IDX_W]), 2'b00})))
    else $error("first-level read wrong");

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid)
    else $error("read strobe longer than one cycle");

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !pending)
    else $error("second read while one pending");

  assert_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> (respPaddr[OFF_W-1:0] == respVaddr[OFF_W-1:0]))
    else $error("page offset not carried");

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> (respValid && $stable(respFault) &&
      $stable(respFaultLevel) && $stable(respVaddr) && $stable(respPaddr)))
    else $error("response changed while stalled");

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respReady) |=> (!respValid && reqReady))
    else $error("response not released");

endmodule

bind tbl_walker walk_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .OFF_W  (OFF_W),
  .VA_W   (VA_W),
  .PA_W   (PA_W)
) u_walkChk (
  .clk            (clk),
  .rstN           (rstN),
  .reqValid       (reqValid),
  .reqReady       (reqReady),
  .reqVaddr       (reqVaddr),
  .tableBase      (tableBase),
  .memReqValid    (memReqValid),
  .memReqAddr     (memReqAddr),
  .memRspValid    (memRspValid),
  .respValid      (respValid),
  .respReady      (respReady),
  .respFault      (respFault),
  .respFaultLevel (respFaultLevel),
  .respVaddr      (respVaddr),
  .respPaddr      (respPaddr)
);

// File: tb/tb_tbl_walker.sv
`timescale 1ns/1ps
module tb_tbl_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqVaddr;
  logic [31:0] tableBase;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        respValid;
  logic        respReady;
  logic        respFault;
  logic        respFaultLevel;
  logic [31:0] respVaddr;
  logic [19:0] respPpn;
  logic        respDirty;
  logic [2:0]  respRights;
  logic [31:0] respPaddr;

  always #2.5 clk = ~clk;

  tbl_walker dut (.*);

  int total = 0;
  int bad   = 0;

  typedef struct {
    bit        fault;
    bit        level;
    bit [31:0] va;
    bit [19:0] ppn;
    bit        dirty;
    bit [2:0]  rights;
    bit [31:0] pa;
  } expResp_t;

  typedef struct {
    bit [31:0] addr;
    bit        second;
  } expRead_t;

  expResp_t respQ[$];
  expRead_t readQ[$];
  bit [31:0] memModel [bit [31:0]];
  bit strayPulse = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rdMem(input bit [31:0] a);
    return memModel.exists(a) ? memModel[a] : 32'h0;
  endfunction

  // kind 0: full mapping, 1: first level invalid, 2: second level invalid
  task automatic setupMap(input bit [31:0] base, input bit [31:0] va, input int kind,
                          input bit [19:0] ppn, input bit [2:0] rights, input bit dirty);
    bit [31:0] l1a, l2t, l2a;
    l1a = base + {20'h0, va[31:22], 2'b00};
    l2t = 32'h0100_0000 + {10'h0, va[31:22], 12'h000};
    l2a = l2t + {20'h0, va[21:12], 2'b00};
    memModel[l1a] = l2t | {31'h0, kind != 1};
    memModel[l2a] = {ppn, 7'h0, rights, dirty, kind != 2};
  endtask

  task automatic doWalk(input bit [31:0] va, input bit [31:0] base,
                        input int busyHold, input bit scrambleBase);
    expResp_t e;
    bit [31:0] a1, e1, a2, e2;
    a1 = base + {20'h0, va[31:22], 2'b00};
    e1 = rdMem(a1);
    readQ.push_back('{a1, 1'b0});
    e = '{default: '0};
    e.va = va;
    if (!e1[0]) begin
      e.fault = 1'b1; e.level = 1'b0;
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      readQ.push_back('{a2, 1'b1});
      e2 = rdMem(a2);
      if (!e2[0]) begin
        e.fault = 1'b1; e.level = 1'b1;
      end else begin
        e.ppn = e2[31:12]; e.dirty = e2[1]; e.rights = e2[4:2];
        e.pa = {e2[31:12], va[11:0]};
      end
    end
    respQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; tableBase = base;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (scrambleBase) tableBase = ~base ^ 32'h0000_1234;
    if (busyHold > 0) begin
      reqVaddr = ~va;
      for (int i = 0; i < busyHold; i++) begin
        chk(reqReady == 1'b0, "R2", "reqReady during walk", {31'h0, reqReady}, 32'h0);
        @(negedge clk);
      end
    end
    reqValid = 1'b0;
    while (respQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // respReady pattern, changed away from the sampling edge
  int readyCnt = 0;
  initial begin
    respReady = 1'b0;
    forever begin
      @(posedge clk);
      #1 respReady = (readyCnt % 3) != 1;
      readyCnt++;
    end
  end

  // memory responder
  initial begin
    int latCnt = 0;
    memRspValid = 1'b0;
    memRspData  = 32'h0;
    @(negedge clk);
    forever begin
      if (rstN && memReqValid) begin
        bit [31:0] a;
        expRead_t x;
        int lat;
        a = memReqAddr;
        if (readQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected memory read", a, 32'h0);
        end else begin
          x = readQ.pop_front();
          chk(a == x.addr, x.second ? "R5" : "R3", "read address", a, x.addr);
        end
        lat = 1 + (latCnt % 3);
        latCnt++;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(!memReqValid, "R9", "read while pending", {31'h0, memReqValid}, 32'h0);
        end
        memRspValid = 1'b1;
        memRspData  = rdMem(a);
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = 32'hA5A5_5A5B;
      end else if (strayPulse) begin
        memRspValid = 1'b1;
        memRspData  = 32'hFFFF_FFFF;
        @(negedge clk);
        memRspValid = 1'b0;
        strayPulse  = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // strobe width monitor
  initial begin
    bit prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && memReqValid)
        chk(!prevReq, "R3", "read strobe width", 32'd2, 32'd1);
      prevReq = rstN && memReqValid;
    end
  end

  // response monitor / scoreboard
  initial begin
    bit       holdPrev = 1'b0;
    bit       released = 1'b0;
    bit [31:0] sVa, sPa;
    bit       sFault, sLvl;
    forever begin
      @(negedge clk);
      if (released) begin
        chk(!respValid && reqReady, "R8", "release after handshake",
            {30'h0, respValid, reqReady}, 32'h1);
        released = 1'b0;
      end
      if (rstN && respValid) begin
        if (holdPrev) begin
          chk(respVaddr == sVa && respPaddr == sPa && respFault == sFault &&
              respFaultLevel == sLvl, "R8", "hold while stalled", respVaddr, sVa);
        end
        if (respReady) begin
          if (respQ.size() == 0) begin
            chk(1'b0, "R2", "unexpected response", respVaddr, 32'h0);
          end else begin
            expResp_t e;
            string tag;
            e = respQ.pop_front();
            tag = !e.fault ? "R7" : (e.level ? "R6" : "R4");
            chk(respFault == e.fault, tag, "fault flag", {31'h0, respFault}, {31'h0, e.fault});
            chk(respVaddr == e.va, tag, "vaddr", respVaddr, e.va);
            if (e.fault) begin
              chk(respFaultLevel == e.level, tag, "fault level",
                  {31'h0, respFaultLevel}, {31'h0, e.level});
            end else begin
              chk(respPpn == e.ppn, tag, "ppn", {12'h0, respPpn}, {12'h0, e.ppn});
              chk(respDirty == e.dirty, tag, "dirty", {31'h0, respDirty}, {31'h0, e.dirty});
              chk(respRights == e.rights, tag, "rights", {29'h0, respRights}, {29'h0, e.rights});
              chk(respPaddr == e.pa, tag, "paddr", respPaddr, e.pa);
            end
          end
          released = 1'b1;
        end
        sVa = respVaddr; sPa = respPaddr; sFault = respFault; sLvl = respFaultLevel;
        holdPrev = !respReady;
      end else begin
        holdPrev = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [31:0] lcg;
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = 32'h0; tableBase = 32'h0;
    repeat (2) @(negedge clk);
    chk(reqReady && !memReqValid && !respValid, "R1", "state in reset",
        {29'h0, reqReady, memReqValid, respValid}, 32'h4);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(reqReady && !memReqValid && !respValid, "R1", "state after reset",
        {29'h0, reqReady, memReqValid, respValid}, 32'h4);

    // R7 full translation, R3 and R5 addresses
    setupMap(32'h0001_0000, 32'h1234_5678, 0, 20'hABCDE, 3'b101, 1'b1);
    doWalk(32'h1234_5678, 32'h0001_0000, 0, 1'b0);
    // R4 first-level invalid
    setupMap(32'h0001_0000, 32'h8000_0abc, 1, 20'h11111, 3'b010, 1'b0);
    doWalk(32'h8000_0abc, 32'h0001_0000, 0, 1'b0);
    // R6 second-level invalid
    setupMap(32'h0001_0000, 32'h4020_3fff, 2, 20'h22222, 3'b111, 1'b1);
    doWalk(32'h4020_3fff, 32'h0001_0000, 0, 1'b0);
    // index boundaries
    setupMap(32'h0002_0000, 32'hFFFF_FFFF, 0, 20'hFFFFF, 3'b111, 1'b0);
    doWalk(32'hFFFF_FFFF, 32'h0002_0000, 0, 1'b0);
    setupMap(32'h0002_0000, 32'h0000_0000, 0, 20'h00001, 3'b000, 1'b1);
    doWalk(32'h0000_0000, 32'h0002_0000, 0, 1'b0);
    // R10 base changed mid-walk
    setupMap(32'h0003_0000, 32'h0765_4321, 0, 20'h3C3C3, 3'b011, 1'b0);
    doWalk(32'h0765_4321, 32'h0003_0000, 0, 1'b1);
    // R2 request held during walk
    setupMap(32'h0003_0000, 32'h2468_ACE0, 0, 20'h13579, 3'b110, 1'b1);
    doWalk(32'h2468_ACE0, 32'h0003_0000, 3, 1'b1);
    // R9 stray data pulse while idle
    strayPulse = 1'b1;
    while (strayPulse) @(negedge clk);
    chk(reqReady && !memReqValid && !respValid, "R9", "stray data ignored",
        {29'h0, reqReady, memReqValid, respValid}, 32'h4);
    doWalk(32'h1234_5678, 32'h0001_0000, 0, 1'b0);

    // mixed walks
    lcg = 32'h1357_9BDF;
    for (int n = 0; n < 24; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      setupMap(32'h0040_0000, lcg, n % 3, lcg[27:8], lcg[6:4], lcg[9]);
      doWalk(lcg, 32'h0040_0000, n % 5 == 0 ? 2 : 0, n[0]);
    end

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule